// File: doc/BRIEF.md
# Pseudo-Cause Interrupt Aggregator

This block merges the pending state of three interrupt groups (receive, transmit and miscellaneous) into one three-bit summary cause register, and from it drives a single level interrupt line to the host. Each group supplies one level input that is high while that group has any unmasked cause pending. The summary bits are sticky. A host read of the summary clears it, so no acknowledge write is ever needed. If a group input is still high, its bit comes back on the next cycle.

A 32-bit software mask register, reset to all ones, gates the summary bits before they reach the interrupt line. Masking only suppresses the line. It never changes the summary state, so a source that is masked and later unmasked still reports what it collected while masked. The host reaches both registers through a simple word-addressed read/write port. Read data is registered and appears one cycle after the read strobe.

Top module: `pseudo_irq_agg`

## Requirements
- R1: A group input that is high at a clock edge sets its summary bit at that edge, and the bit stays set until the summary is read, even if the input has dropped.
- R2: In the summary word read at address 0, receive is bit 0, transmit is bit 1 and miscellaneous is bit 2; all other bits read zero.
- R3: A read strobe at address 0 returns the summary value held before that edge on the read data port in the following cycle, and clears the summary. Any group input still high during the read cycle sets its bit again at the same edge, so a held input reads back as set on every read.
- R4: After reset the summary is zero, the interrupt line is low and the mask (address 1) reads 0xFFFFFFFF.
- R5: A write strobe at address 1 loads all 32 bits of the mask, and a read at address 1 returns them. A read at any address other than 0 or 1 returns zero.
- R6: The interrupt line is the OR over bits 0 to 2 of (summary AND NOT mask), registered once. It rises one cycle after the summary bit is set and falls one cycle after the summary is cleared or the bit is masked.
- R7: The interrupt line is never high in a cycle that follows a cycle in which every set summary bit was masked. Changing the mask leaves the summary contents unchanged.
- R8: Writing 0xFFFFFFF8 to the mask unmasks exactly the three sources. Writing 0xFFFFFFFE unmasks receive only, so a transmit event leaves the line low.
- R9: A write to address 0 has no effect on the summary, and a read of address 1 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_pend_i | input | 1 | Receive group has an unmasked cause pending |
| tx_pend_i | input | 1 | Transmit group has an unmasked cause pending |
| misc_pend_i | input | 1 | Miscellaneous group has an unmasked cause pending |
| reg_addr_i | input | ADDR_W | Register word address (0 summary, 1 mask) |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Host interrupt line |

## Verification
The sources are tried one at a time as single-cycle pulses, which separates the sticky capture and the bit positions from plain pass-through of the inputs. They are also held high across reads, which shows that clear-on-read is followed by an immediate set. Combined pulses under partial masks (receive only, all three, none) show that the mask gates only the line while the summary keeps every event. Writes to the summary address and reads of the mask while a bit is pending show whether either access disturbs the summary.

// File: rtl/pia_pkg.sv
// Shared definitions for the pseudo-cause interrupt aggregator.
// Assumes three groups with a fixed index order inside the block.
package pia_pkg;
    localparam int GRP_N    = 3;
    localparam int GRP_RX   = 0;
    localparam int GRP_TX   = 1;
    localparam int GRP_MISC = 2;

    typedef enum logic [1:0] {
        REG_CAUSE = 2'd0,
        REG_MASK  = 2'd1,
        REG_NONE  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/pia_cause_reg.sv
// Sticky summary cause register with clear-on-read.
// Assumes clr_i is a single-cycle read strobe; an input high in the
// clearing cycle is captured at the same edge, so no event is lost.
module pia_cause_reg #(
    parameter int GRP_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_N-1:0] grp_i,
    input  logic             clr_i,
    output logic [GRP_N-1:0] cause_o
);
    logic [GRP_N-1:0] cause_q;

    // Accumulate group levels; a read clears the bits held so far
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (clr_i ? '0 : cause_q) | grp_i;
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/pia_mask_reg.sv
// Software mask register, all ones out of reset (everything masked).
// Assumes wr_i is already qualified by the address decode.
module pia_mask_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o
);
    logic [DATA_W-1:0] mask_q;

    // Load the full word on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '1;
        else if (wr_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/pia_irq_gen.sv
// Registered interrupt line: OR of summary bits left open by the mask.
// Assumes mask_i is already reduced to one bit per group.
module pia_irq_gen #(
    parameter int GRP_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_N-1:0] cause_i,
    input  logic [GRP_N-1:0] mask_i,
    output logic             irq_o
);
    logic irq_q;

    // Register the gated OR so the line is glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_i & ~mask_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/pseudo_irq_agg.sv
// Top of the pseudo-cause interrupt aggregator: register decode, summary
// placement in the read word, mask bit selection and the interrupt line.
// Assumes at most one of reg_wr_i / reg_rd_i per cycle from the host.
module pseudo_irq_agg #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int RX_BIT   = 0,
    parameter int TX_BIT   = 1,
    parameter int MISC_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pend_i,
    input  logic              tx_pend_i,
    input  logic              misc_pend_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    import pia_pkg::*;

    localparam int BIT_POS [GRP_N] = '{RX_BIT, TX_BIT, MISC_BIT};

    logic [GRP_N-1:0]  grp;
    logic [GRP_N-1:0]  cause;
    logic [GRP_N-1:0]  mask_sel;
    logic [DATA_W-1:0] mask_word;
    logic [DATA_W-1:0] cause_word;
    logic [DATA_W-1:0] rdata_q;
    reg_sel_e          sel;
    logic              rd_cause;
    logic              wr_mask;

    assign grp[GRP_RX]   = rx_pend_i;
    assign grp[GRP_TX]   = tx_pend_i;
    assign grp[GRP_MISC] = misc_pend_i;

    // Decode the word address into a register select
    always_comb begin
        if (reg_addr_i == ADDR_W'(0))      sel = REG_CAUSE;
        else if (reg_addr_i == ADDR_W'(1)) sel = REG_MASK;
        else                               sel = REG_NONE;
    end

    assign rd_cause = reg_rd_i && (sel == REG_CAUSE);
    assign wr_mask  = reg_wr_i && (sel == REG_MASK);

    pia_cause_reg #(.GRP_N(GRP_N)) cause_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_i   (grp),
        .clr_i   (rd_cause),
        .cause_o (cause)
    );

    pia_mask_reg #(.DATA_W(DATA_W)) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_word)
    );

    // Place each group bit at its word position and pick its mask bit
    for (genvar g = 0; g < GRP_N; g++) begin : g_place
        assign mask_sel[g] = mask_word[BIT_POS[g]];
    end

    // Build the summary word from the group bits
    always_comb begin
        cause_word = '0;
        for (int g = 0; g < GRP_N; g++) begin
            cause_word[BIT_POS[g]] = cause[g];
        end
    end

    pia_irq_gen #(.GRP_N(GRP_N)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause),
        .mask_i  (mask_sel),
        .irq_o   (irq_o)
    );

    // Register read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd_i) begin
            case (sel)
                REG_CAUSE: rdata_q <= cause_word;
                REG_MASK:  rdata_q <= mask_word;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/pia_checker.sv
// Property checker for the aggregator, attached by bind below.
// Assumes cause and mask_sel use the internal group index order.
module pia_checker #(
    parameter int GRP_N  = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GRP_N-1:0]  grp,
    input logic [GRP_N-1:0]  cause,
    input logic [GRP_N-1:0]  mask_sel,
    input logic [DATA_W-1:0] mask_word,
    input logic              rd_cause,
    input logic              irq_o
);
    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cause |=> ((cause & $past(cause)) == $past(cause)));

    // R3
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cause |=> (cause == $past(grp)));

    // R4
    reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask_word));

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(cause & ~mask_sel)));

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & ~mask_sel) == '0) |=> !irq_o);
endmodule

bind pseudo_irq_agg pia_checker #(.GRP_N(3), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp       (grp),
    .cause     (cause),
    .mask_sel  (mask_sel),
    .mask_word (mask_word),
    .rd_cause  (rd_cause),
    .irq_o     (irq_o)
);

// File: tb/pseudo_irq_agg_tb_top.sv
// Directed bench for the pseudo-cause interrupt aggregator.
module pseudo_irq_agg_tb_top;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx = 1'b0, tx = 1'b0, misc = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pseudo_irq_agg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_pend_i   (rx),
        .tx_pend_i   (tx),
        .misc_pend_i (misc),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [2:0] v);
        {misc, tx, rx} = v;
        @(negedge clk);
        {misc, tx, rx} = 3'b000;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R4 irq after reset", 32'(irq), 32'h0);
        reg_read(4'd0, d); check("R4 summary after reset", d, 32'h0);
        reg_read(4'd1, d); check("R4 mask after reset", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_sticky_masked();
        logic [31:0] d;
        pulse(3'b001);
        tick(3);
        check("R7 line low under full mask", 32'(irq), 32'h0);
        reg_read(4'd0, d); check("R1 R2 receive sticky at bit 0", d, 32'h1);
        reg_read(4'd0, d); check("R3 cleared by read", d, 32'h0);
    endtask

    task automatic t_unmask_latency();
        logic [31:0] d;
        reg_write(4'd1, 32'hFFFF_FFF8);
        reg_read(4'd1, d); check("R5 mask readback", d, 32'hFFFF_FFF8);
        pulse(3'b010);
        check("R6 line still low one edge after pulse", 32'(irq), 32'h0);
        tick(1);
        check("R6 R8 line high two edges after pulse", 32'(irq), 32'h1);
        reg_read(4'd0, d); check("R2 transmit at bit 1", d, 32'h2);
        tick(1);
        check("R6 line low after summary read", 32'(irq), 32'h0);
        reg_read(4'd5, d); check("R5 unused address reads zero", d, 32'h0);
    endtask

    task automatic t_held_level();
        logic [31:0] d;
        misc = 1'b1;
        tick(1);
        reg_read(4'd0, d); check("R2 misc at bit 2", d, 32'h4);
        reg_read(4'd0, d); check("R3 held input set again after read", d, 32'h4);
        misc = 1'b0;
        reg_read(4'd0, d); check("R3 bit captured during last read", d, 32'h4);
        reg_read(4'd0, d); check("R3 clear once input drops", d, 32'h0);
    endtask

    task automatic t_partial_mask();
        logic [31:0] d;
        reg_write(4'd1, 32'hFFFF_FFFE);
        pulse(3'b010);
        tick(2);
        check("R8 transmit masked keeps line low", 32'(irq), 32'h0);
        pulse(3'b001);
        tick(1);
        check("R8 receive unmasked raises line", 32'(irq), 32'h1);
        reg_write(4'd1, 32'hFFFF_FFFF);
        tick(1);
        check("R7 line falls after full mask", 32'(irq), 32'h0);
        reg_read(4'd0, d); check("R7 mask leaves summary intact", d, 32'h3);
    endtask

    task automatic t_ignored_access();
        logic [31:0] d;
        pulse(3'b100);
        reg_write(4'd0, 32'h0);
        reg_read(4'd1, d); check("R9 mask read value", d, 32'hFFFF_FFFF);
        reg_read(4'd0, d); check("R9 summary kept after write and mask read", d, 32'h4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_sticky_masked();
        t_unmask_latency();
        t_held_level();
        t_partial_mask();
        t_ignored_access();
        tick(2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule